// File: doc/BRIEF.md
# Clock-Ready Interrupt Enable Register with Per-Bit Security Filtering

This block is a single-word, memory-mapped register that holds one interrupt enable for each clock-source ready event. With the default of five sources, bits 0 to 3 enable the four oscillator-stable events and bit 4 enables the PLL-lock event. A one-cycle register bus carries a secure attribute and a privileged attribute with every access. The block combines the stored enables with sticky ready flags and drives a single level-sensitive interrupt line.

Each enable bit has its own security input. It also has privilege protection, which comes from one of two shared controls: one serves secure bits and the other serves non-secure bits. A single access is filtered bit by bit. Bits the access may reach are read and written normally. Bits it may not reach read as zero and keep their value, and the access raises no error. The bus has no error response of any kind.

Top module: `clk_rdy_irq_en`

## Requirements
- R1: After reset, every enable bit is 0, `irq` is low and `bus_rdata` is all zeros.
- R2: A write that is permitted for bit i loads `bus_wdata[i]` into enable i. A 1 enables the event and a 0 disables it, so software can both set and clear every bit.
- R3: A read at the register address returns the filtered enables in `bus_rdata[NUM_SRC-1:0]` on the cycle after the access. All higher bits read as 0. On cycles with no read access, `bus_rdata` is 0.
- R4: When `src_secure[i]` is 1, an access with `bus_secure`=0 reads bit i as 0 and leaves bit i unchanged.
- R5: For a bit with `src_secure[i]`=1, a secure access with `bus_priv`=0 is blocked (read as zero, write ignored) when `sec_priv_only`=1. The same access is permitted when `sec_priv_only`=0.
- R6: For a bit with `src_secure[i]`=0, an access with `bus_priv`=0 is blocked when `ns_priv_only`=1 and permitted when `ns_priv_only`=0. The `sec_priv_only` control has no effect on such bits.
- R7: Filtering is applied per bit. In one write, the permitted bits take the new data and the blocked bits keep their old values.
- R8: `irq` is high exactly when some `rdy_flag[i]` and enable i are both 1.
- R9: An access to any address other than `REG_ADDR` changes no enable bit and returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address of the access |
| bus_wdata | input | DATA_W | Write data |
| bus_secure | input | 1 | Access is secure |
| bus_priv | input | 1 | Access is privileged |
| bus_rdata | output | DATA_W | Registered read data |
| src_secure | input | NUM_SRC | Per-source security attribute (1 = secure) |
| sec_priv_only | input | 1 | Secure bits require privileged access |
| ns_priv_only | input | 1 | Non-secure bits require privileged access |
| rdy_flag | input | NUM_SRC | Sticky ready-event flags |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with five sources, a 32-bit data path, an 8-bit address and `REG_ADDR` set to 0x14. Because the register does not sit at address zero, an all-zero address is a real decode miss, and write data with all upper bits set shows that nothing leaks above bit 4. With five sources, a single security vector such as 10011 splits one access across secure and non-secure bits. The bench steps through every combination of access attribute and privilege control against that split.

// File: rtl/clk_rdy_irq_en.sv
module clk_rdy_irq_en #(
  parameter int NUM_SRC = 5,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] REG_ADDR = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  input  logic               bus_secure,
  input  logic               bus_priv,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [NUM_SRC-1:0] src_secure,
  input  logic               sec_priv_only,
  input  logic               ns_priv_only,
  input  logic [NUM_SRC-1:0] rdy_flag,
  output logic               irq
);

  localparam int PAD_W = DATA_W - NUM_SRC;

  logic [NUM_SRC-1:0] en_q;
  logic [NUM_SRC-1:0] rdata_q;
  logic [NUM_SRC-1:0] reach;
  logic               hit;
  logic               unused_wdata_hi;

  assign hit = bus_sel && (bus_addr == REG_ADDR);
  assign unused_wdata_hi = ^bus_wdata[DATA_W-1:NUM_SRC];

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_filt
    logic sec_ok, priv_ok;
    assign sec_ok  = bus_secure || !src_secure[i];
    assign priv_ok = bus_priv || !(src_secure[i] ? sec_priv_only : ns_priv_only);
    assign reach[i] = sec_ok && priv_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (hit && bus_wr) begin
      en_q <= (bus_wdata[NUM_SRC-1:0] & reach) | (en_q & ~reach);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= (hit && !bus_wr) ? (en_q & reach) : '0;
  end

  assign bus_rdata = {{PAD_W{1'b0}}, rdata_q};
  assign irq = |(en_q & rdy_flag);

endmodule

// File: rtl/clk_rdy_irq_en_chk.sv
module clk_rdy_irq_en_chk #(
  parameter int NUM_SRC = 5,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] REG_ADDR = '0
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_sel,
  input logic               bus_wr,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic               bus_secure,
  input logic [DATA_W-1:0]  bus_rdata,
  input logic [NUM_SRC-1:0] src_secure,
  input logic [NUM_SRC-1:0] rdy_flag,
  input logic [NUM_SRC-1:0] en_q,
  input logic               irq
);

  logic acc_hit;
  assign acc_hit = bus_sel && (bus_addr == REG_ADDR);

  AST_RDATA_HI_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[DATA_W-1:NUM_SRC] == '0);  // R3

  AST_IDLE_RDATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_hit && !bus_wr) |=> bus_rdata == '0);  // R3

  AST_MISS_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_hit && bus_wr) |=> $stable(en_q));  // R9

  AST_NS_READ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_hit && !bus_wr && !bus_secure) |=> ((bus_rdata[NUM_SRC-1:0] & $past(src_secure)) == '0));  // R4

  AST_NO_FLAG_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_flag == '0) |-> !irq);  // R8

  AST_NO_EN_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !irq);  // R8

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    AST_NS_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_hit && bus_wr && !bus_secure && src_secure[i]) |=> $stable(en_q[i]));  // R4
  end

endmodule

bind clk_rdy_irq_en clk_rdy_irq_en_chk #(
  .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_ADDR(REG_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_secure(bus_secure), .bus_rdata(bus_rdata),
  .src_secure(src_secure), .rdy_flag(rdy_flag), .en_q(en_q), .irq(irq)
);

// File: tb/clk_rdy_irq_en_bench.sv
module clk_rdy_irq_en_bench;
  localparam int N = 5;
  localparam int AW = 8;
  localparam int DW = 32;
  localparam logic [AW-1:0] RA = 8'h14;

  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_wr = 0, bus_secure = 0, bus_priv = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic [N-1:0] src_secure = '0, rdy_flag = '0;
  logic sec_priv_only = 0, ns_priv_only = 0;
  logic irq;

  int n_run = 0, n_fail = 0;
  logic [DW-1:0] exp_q[$];
  string tag_q[$];
  logic rd_launched = 0;

  always #4 clk = ~clk;

  clk_rdy_irq_en #(.NUM_SRC(N), .ADDR_W(AW), .DATA_W(DW), .REG_ADDR(RA)) u_clk_rdy_irq_en (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_secure(bus_secure), .bus_priv(bus_priv),
    .bus_rdata(bus_rdata), .src_secure(src_secure), .sec_priv_only(sec_priv_only),
    .ns_priv_only(ns_priv_only), .rdy_flag(rdy_flag), .irq(irq));

  task automatic check(string tag, logic [DW-1:0] got, logic [DW-1:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic access(logic wr, logic [AW-1:0] a, logic [DW-1:0] d,
                        logic sec, logic pr, logic [DW-1:0] exp, string tag);
    @(negedge clk);
    bus_sel = 1; bus_wr = wr; bus_addr = a; bus_wdata = d;
    bus_secure = sec; bus_priv = pr;
    if (!wr) begin exp_q.push_back(exp); tag_q.push_back(tag); end
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  always @(posedge clk) rd_launched <= bus_sel && !bus_wr;

  always @(negedge clk) begin
    if (rd_launched) begin
      if (exp_q.size() == 0) check("scoreboard underflow", 1, 0);
      else check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
    end
  end

  initial begin
    #1_600_000;
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 rdata reset", bus_rdata, 0);
    check("R1 irq reset", {31'b0, irq}, 0);
    rst_n = 1;
    access(0, RA, 0, 1, 1, 32'h00, "R1 enables reset");
    access(1, RA, 32'h1F, 0, 0, 0, "");
    access(0, RA, 0, 0, 0, 32'h1F, "R2 set all");
    access(1, RA, 32'h0A, 0, 0, 0, "");
    access(0, RA, 0, 0, 0, 32'h0A, "R2 clear some");
    access(1, RA, 32'hFFFF_FFE5, 0, 0, 0, "");
    access(0, RA, 0, 0, 0, 32'h05, "R3 upper bits zero");
    src_secure = 5'b10011;
    access(1, RA, 32'h00, 0, 1, 0, "");
    access(0, RA, 0, 0, 1, 32'h00, "R4 ns read masked");
    access(0, RA, 0, 1, 1, 32'h01, "R7 partial write");
    access(1, RA, 32'h1F, 1, 1, 0, "");
    access(0, RA, 0, 0, 1, 32'h0C, "R4 ns read of mixed");
    sec_priv_only = 1;
    access(1, RA, 32'h00, 1, 0, 0, "");
    access(0, RA, 0, 1, 0, 32'h00, "R5 unpriv read blocked");
    access(0, RA, 0, 1, 1, 32'h13, "R5 unpriv write blocked");
    sec_priv_only = 0; ns_priv_only = 1;
    access(1, RA, 32'h1F, 0, 0, 0, "");
    access(0, RA, 0, 1, 1, 32'h13, "R6 ns unpriv write blocked");
    access(1, RA, 32'h0C, 1, 0, 0, "");
    access(0, RA, 0, 1, 1, 32'h00, "R6 ns bits held, R5 sec bits open");
    access(1, RA, 32'h1F, 1, 0, 0, "");
    access(0, RA, 0, 1, 1, 32'h13, "R5 secure unpriv allowed");
    access(1, 8'h00, 32'h00, 1, 1, 0, "");
    access(0, 8'h00, 0, 1, 1, 32'h00, "R9 miss reads zero");
    access(0, RA, 0, 1, 1, 32'h13, "R9 miss write ignored");
    @(negedge clk);
    rdy_flag = 5'b01100; #1;
    check("R8 flag without enable", {31'b0, irq}, 0);
    rdy_flag = 5'b10000; #1;
    check("R8 enabled flag", {31'b0, irq}, 1);
    rdy_flag = 5'b00000; #1;
    check("R8 flag cleared", {31'b0, irq}, 0);
    rdy_flag = 5'b11111;
    access(1, RA, 32'h00, 1, 1, 0, "");
    #1;
    check("R8 all disabled", {31'b0, irq}, 0);
    repeat (3) @(negedge clk);
    check("R3 scoreboard drained", exp_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule